// File: doc/BRIEF.md
# Debug Register Access Command Engine

This block is the command processor behind a background debug port. A serial front end hands it 16-bit words one at a time; the first word of each exchange is a command, and the words that follow are either write operands or polling slots that pull results out. For every word it accepts, the engine returns exactly one 17-bit response: a status flag in bit 16 and 16 data bits below it. A set flag marks an illegal command, a not-ready placeholder or a refused transfer.

Two commands are decoded: a register read and a register write, each naming one of sixteen 32-bit core registers (eight data, eight address). The register file sits outside the block behind a plain index/read-data/write-strobe port, and a halted flag tells the engine whether the core may be touched. A small programmable access delay models a slow register file. This lets a host that polls too early see not-ready answers.

Top module: `dbg_reg_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge the engine returns to waiting for a command word, `rsp_valid` and `rf_we` are 0 and `cmd_ready` is 1.
- R2: A command word with bits 15:12 = 0x2, bits 11:8 = 0x1 and bits 7:4 = 0x8 is a register read of index bits 3:0 (bit 3 = 1 selects address register bits 2:0, bit 3 = 0 a data register). When `core_halted` is 1 its slot is answered with acknowledge, status 0 and data 0x0000, and `rf_idx` carries bits 3:0.
- R3: After a read, the next polling slots (word content ignored) return the 32-bit register value as two status-0 words, bits 31:16 first and bits 15:0 second, after which the engine waits for a command again.
- R4: A read samples `access_latency` (L, 0..3) when the command is accepted and captures the register value L+1 cycles after the accepting edge. A polling slot accepted before then is answered not-ready, status 1 and data 0x0000, and the engine keeps waiting.
- R5: A command word with bits 15:12 = 0x2, bits 11:8 = 0x0 and bits 7:4 = 0x8 is a register write of index bits 3:0. The command slot is acknowledged, and so is the first operand slot, which holds bits 31:16. If the core was halted, the second operand slot, which holds bits 15:0, is answered with command-complete, status 0 and data 0xFFFF. All 32 bits of the register are then written by a single-cycle `rf_we` pulse.
- R6: If `core_halted` is 0 when a read or write command is accepted, the refused transfer is answered with bus error, status 1 and data 0x0001. For a read this answer is given on the command slot and no data slots follow. For a write both operands are still consumed, the bus error is given on the last operand slot, and `rf_we` stays 0.
- R7: Any other word in command position is answered as an illegal command, status 1 and data 0xFFFF. It touches no register, and the next word is again decoded as a command.
- R8: Each accepted word (`cmd_valid` and `cmd_ready` high at an edge) produces exactly one response, in order. `cmd_ready` is low while a response is pending. A pending response holds its value until `rsp_ready` takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Incoming word is valid |
| cmd_ready | output | 1 | Engine can take a word |
| cmd_word | input | 16 | Command, operand or polling word |
| rsp_valid | output | 1 | Response word is valid |
| rsp_ready | input | 1 | Front end takes the response |
| rsp_word | output | 17 | Bit 16 status, bits 15:0 data |
| core_halted | input | 1 | Core is halted and may be accessed |
| access_latency | input | 2 | Register read delay in cycles |
| rf_idx | output | 4 | Register index: bit 3 address/data, bits 2:0 number |
| rf_rdata | input | 32 | Read data of the indexed register |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | 32 | Register write data |

## Verification
Reads are run against both data and address registers whose halves hold distinct bytes. This shows the index decode of bit 3 and whether the two result words come out in the right order. Each access delay from 0 to 3 is polled at full rate, so the exact number of not-ready answers is predicted and a wrong capture cycle shows up. A write followed by read-backs of the target and a neighbour shows that all 32 bits land in the right place. Refused reads and writes, near-miss command codes, and a stalled response consumer then show that refusal and illegal words leave the registers untouched and that a held response stays stable.

// File: rtl/dbg_cmd_pkg.sv
// Package: shared types and command field constants of the debug register
// access engine. Assumes a fixed 16-bit command word layout.
package dbg_cmd_pkg;

    localparam int CMD_W     = 16;
    localparam int REG_IDX_W = 4;

    // Fixed fields of a register access command word.
    localparam logic [3:0] FLD_GROUP     = 4'h2;  // bits 15:12
    localparam logic [3:0] FLD_READ_OP   = 4'h1;  // bits 11:8, read
    localparam logic [3:0] FLD_WRITE_OP  = 4'h0;  // bits 11:8, write
    localparam logic [3:0] FLD_SIZE      = 4'h8;  // bits 7:4

    // Kind of word seen in command position.
    typedef enum logic [1:0] {
        KIND_ILLEGAL = 2'd0,
        KIND_READ    = 2'd1,
        KIND_WRITE   = 2'd2
    } cmd_kind_t;

    // Sequencer state.
    typedef enum logic [1:0] {
        SEQ_CMD     = 2'd0,
        SEQ_RD_WAIT = 2'd1,
        SEQ_RD_OUT  = 2'd2,
        SEQ_WR_IN   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
// Module: dbg_cmd_decode
// Classifies a word taken in command position as register read, register
// write or illegal, and extracts the register index. Purely combinational;
// assumes the word is only meaningful while the sequencer waits for a command.
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [CMD_W-1:0]     word_i,
    output cmd_kind_t            kind_o,
    output logic [REG_IDX_W-1:0] idx_o
);

    logic frame_ok;

    // Decode the fixed group and size fields, then the operation field.
    always_comb begin
        frame_ok = (word_i[15:12] == FLD_GROUP) && (word_i[7:4] == FLD_SIZE);
        if (frame_ok && word_i[11:8] == FLD_READ_OP) begin
            kind_o = KIND_READ;
        end else if (frame_ok && word_i[11:8] == FLD_WRITE_OP) begin
            kind_o = KIND_WRITE;
        end else begin
            kind_o = KIND_ILLEGAL;
        end
        idx_o = word_i[REG_IDX_W-1:0];
    end

endmodule

// File: rtl/dbg_access_timer.sv
// Module: dbg_access_timer
// Counts the programmed register access delay. A start pulse loads the delay;
// done is high for one cycle once the count has run down to zero, which is
// LAT+1 cycles after the start edge. Assumes start only while idle.
module dbg_access_timer #(
    parameter int LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             done_o
);

    logic             running_q;
    logic [LAT_W-1:0] cnt_q;

    // Done when a running count has reached zero.
    assign done_o = running_q && (cnt_q == '0);

    // Load on start, count down while running, stop when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start_i) begin
            running_q <= 1'b1;
            cnt_q     <= lat_i;
        end else if (done_o) begin
            running_q <= 1'b0;
        end else if (running_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TIMER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> running_q && cnt_q == $past(lat_i)); // R4

    AST_TIMER_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R4

endmodule

// File: rtl/dbg_rsp_slot.sv
// Module: dbg_rsp_slot
// Single-entry response holding register with a valid/ready handshake.
// A load fills it, the consumer empties it; free_o tells the sequencer that a
// new word may be accepted. Assumes load only while free.
module dbg_rsp_slot #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         rdy_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         free_o
);

    logic         valid_q;
    logic [W-1:0] data_q;

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign free_o  = !valid_q;

    // Fill on load, drain when the consumer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
        end else if (valid_q && rdy_i) begin
            valid_q <= 1'b0;
        end
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !rdy_i) |=> valid_q && $stable(data_q)); // R8

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_q); // R8

endmodule

// File: rtl/dbg_reg_cmd_engine.sv
// Module: dbg_reg_cmd_engine
// Debug command sequencer for reads and writes of core address/data
// registers. Every accepted word yields one 17-bit response (status, data).
// Reads wait a programmable delay and return DATA_W bits as WORD_W-bit words,
// most significant first; writes gather operand words the same way.
// Assumes an external register file with combinational read of rf_idx.
module dbg_reg_cmd_engine
    import dbg_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WORD_W = CMD_W,
    parameter int IDX_W  = REG_IDX_W,
    parameter int LAT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [WORD_W-1:0] cmd_word,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W:0]   rsp_word,
    input  logic              core_halted,
    input  logic [LAT_W-1:0]  access_latency,
    output logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata
);

    localparam int NUM_WORDS = DATA_W / WORD_W;
    localparam int PART_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int RSP_W     = WORD_W + 1;
    localparam int HOLD_W    = DATA_W - WORD_W;
    localparam logic [PART_W-1:0] LAST_PART = PART_W'(NUM_WORDS - 1);

    // Response codes: status bit on top of the data word.
    localparam logic [RSP_W-1:0] RSP_ACK       = {1'b0, {WORD_W{1'b0}}};
    localparam logic [RSP_W-1:0] RSP_DONE      = {1'b0, {WORD_W{1'b1}}};
    localparam logic [RSP_W-1:0] RSP_NOT_READY = {1'b1, {WORD_W{1'b0}}};
    localparam logic [RSP_W-1:0] RSP_BUS_ERR   = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [RSP_W-1:0] RSP_ILLEGAL   = {1'b1, {WORD_W{1'b1}}};

    seq_state_t           st_q, st_d;
    logic [PART_W-1:0]    part_q, part_d;
    logic [IDX_W-1:0]     idx_q, idx_d;
    logic                 halt_q, halt_d;
    logic [DATA_W-1:0]    rd_data_q, rd_data_d;
    logic [HOLD_W-1:0]    wr_hold_q, wr_hold_d;
    logic                 we_q, we_d;
    logic [DATA_W-1:0]    wdata_q, wdata_d;

    logic                 accept;
    logic                 slot_free;
    logic                 rsp_load;
    logic [RSP_W-1:0]     rsp_data;
    logic                 tmr_start;
    logic                 tmr_done;
    cmd_kind_t            dec_kind;
    logic [IDX_W-1:0]     dec_idx;
    logic [DATA_W-1:0]    wr_full;
    logic [PART_W-1:0]    rd_sel;
    logic [WORD_W-1:0]    rd_words [NUM_WORDS];

    // Split the captured read value into response-sized words.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_rd_split
        assign rd_words[g] = rd_data_q[g*WORD_W +: WORD_W];
    end

    assign accept    = cmd_valid && cmd_ready;
    assign cmd_ready = slot_free;
    assign rd_sel    = LAST_PART - part_q;
    assign wr_full   = {wr_hold_q, cmd_word};
    assign rf_idx    = idx_q;
    assign rf_we     = we_q;
    assign rf_wdata  = wdata_q;

    dbg_cmd_decode u_decode (
        .word_i (cmd_word),
        .kind_o (dec_kind),
        .idx_o  (dec_idx)
    );

    dbg_access_timer #(.LAT_W(LAT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .lat_i   (access_latency),
        .done_o  (tmr_done)
    );

    dbg_rsp_slot #(.W(RSP_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (rsp_load),
        .data_i  (rsp_data),
        .rdy_i   (rsp_ready),
        .valid_o (rsp_valid),
        .data_o  (rsp_word),
        .free_o  (slot_free)
    );

    // Next-state, response and register-write selection per sequencer state.
    always_comb begin
        st_d      = st_q;
        part_d    = part_q;
        idx_d     = idx_q;
        halt_d    = halt_q;
        rd_data_d = rd_data_q;
        wr_hold_d = wr_hold_q;
        we_d      = 1'b0;
        wdata_d   = wdata_q;
        rsp_load  = accept;
        rsp_data  = RSP_ACK;
        tmr_start = 1'b0;
        unique case (st_q)
            SEQ_CMD: begin
                if (accept) begin
                    part_d = '0;
                    unique case (dec_kind)
                        KIND_READ: begin
                            if (core_halted) begin
                                idx_d     = dec_idx;
                                tmr_start = 1'b1;
                                st_d      = SEQ_RD_WAIT;
                            end else begin
                                rsp_data = RSP_BUS_ERR;
                            end
                        end
                        KIND_WRITE: begin
                            idx_d  = dec_idx;
                            halt_d = core_halted;
                            st_d   = SEQ_WR_IN;
                        end
                        default: rsp_data = RSP_ILLEGAL;
                    endcase
                end
            end
            SEQ_RD_WAIT: begin
                rsp_data = RSP_NOT_READY;
                if (tmr_done) begin
                    rd_data_d = rf_rdata;
                    st_d      = SEQ_RD_OUT;
                end
            end
            SEQ_RD_OUT: begin
                rsp_data = {1'b0, rd_words[rd_sel]};
                if (accept) begin
                    if (part_q == LAST_PART) begin
                        st_d = SEQ_CMD;
                    end else begin
                        part_d = part_q + 1'b1;
                    end
                end
            end
            SEQ_WR_IN: begin
                if (accept) begin
                    if (part_q == LAST_PART) begin
                        st_d = SEQ_CMD;
                        if (halt_q) begin
                            we_d     = 1'b1;
                            wdata_d  = wr_full;
                            rsp_data = RSP_DONE;
                        end else begin
                            rsp_data = RSP_BUS_ERR;
                        end
                    end else begin
                        wr_hold_d = wr_full[HOLD_W-1:0];
                        part_d    = part_q + 1'b1;
                    end
                end
            end
            default: st_d = SEQ_CMD;
        endcase
    end

    // Sequencer and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= SEQ_CMD;
            part_q    <= '0;
            idx_q     <= '0;
            halt_q    <= 1'b0;
            rd_data_q <= '0;
            wr_hold_q <= '0;
            we_q      <= 1'b0;
            wdata_q   <= '0;
        end else begin
            st_q      <= st_d;
            part_q    <= part_d;
            idx_q     <= idx_d;
            halt_q    <= halt_d;
            rd_data_q <= rd_data_d;
            wr_hold_q <= wr_hold_d;
            we_q      <= we_d;
            wdata_q   <= wdata_d;
        end
    end

    AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rsp_valid); // R8

    AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_RD_WAIT && accept) |=> rsp_word == RSP_NOT_READY); // R4

    AST_ILLEGAL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_CMD && accept && dec_kind == KIND_ILLEGAL)
        |=> rsp_word == RSP_ILLEGAL && st_q == SEQ_CMD); // R7

    AST_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_CMD && accept && dec_kind == KIND_READ && !core_halted)
        |=> rsp_word == RSP_BUS_ERR && st_q == SEQ_CMD); // R6

    AST_NO_WRITE_UNHALTED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(halt_q)); // R6

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we); // R5

endmodule

// File: tb/dbg_reg_cmd_engine_tb.sv
// Scoreboard bench: driver tasks queue the expected response of every word
// they send; a monitor pops and compares each response as it is taken.
module dbg_reg_cmd_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;

    localparam logic [16:0] E_ACK  = 17'h0_0000;
    localparam logic [16:0] E_DONE = 17'h0_FFFF;
    localparam logic [16:0] E_NRDY = 17'h1_0000;
    localparam logic [16:0] E_BERR = 17'h1_0001;
    localparam logic [16:0] E_ILL  = 17'h1_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        rsp_ready = 1'b1;
    logic        core_halted = 1'b1;
    logic [1:0]  access_latency = '0;
    logic [31:0] rf_rdata;
    logic        cmd_ready;
    logic        rsp_valid;
    logic [16:0] rsp_word;
    logic [3:0]  rf_idx;
    logic        rf_we;
    logic [31:0] rf_wdata;

    int checks = 0;
    int errors = 0;
    int we_pulses = 0;
    bit finished = 1'b0;

    logic [16:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] rf_mem [NREG];
    logic [31:0] shadow [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_reg_cmd_engine dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_word       (cmd_word),
        .rsp_valid      (rsp_valid),
        .rsp_ready      (rsp_ready),
        .rsp_word       (rsp_word),
        .core_halted    (core_halted),
        .access_latency (access_latency),
        .rf_idx         (rf_idx),
        .rf_rdata       (rf_rdata),
        .rf_we          (rf_we),
        .rf_wdata       (rf_wdata)
    );

    function automatic logic [31:0] init_val(int i);
        return {8'(i * 17), 8'hC3, 8'(i), 8'h5A};
    endfunction

    // External register file model and write-strobe counter.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_mem[i] <= init_val(i);
        end else if (rf_we) begin
            rf_mem[rf_idx] <= rf_wdata;
            we_pulses++;
        end
    end
    assign rf_rdata = rf_mem[rf_idx];

    // Monitor: compare each consumed response with the queue head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8: unexpected response actual=%h expected=none", rsp_word);
            end else begin
                automatic logic [16:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rsp_word !== e) begin
                    errors++;
                    $display("FAIL %s: response actual=%h expected=%h", t, rsp_word, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected answer, then hand one word over.
    task automatic send(input logic [15:0] w, input logic [16:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] idx, input logic [1:0] lat, input string tag);
        automatic int nr = (int'(lat) + 1) / 2;
        access_latency = lat;
        send(16'h2180 | 16'(idx), E_ACK, "R2");
        for (int k = 0; k < nr; k++) send(16'h0000, E_NRDY, "R4");
        send(16'h0000, {1'b0, shadow[idx][31:16]}, tag);
        send(16'h0000, {1'b0, shadow[idx][15:0]}, tag);
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [31:0] d, input bit halted);
        core_halted = halted;
        send(16'h2080 | 16'(idx), E_ACK, "R5");
        core_halted = 1'b1;
        send(d[31:16], E_ACK, "R5");
        send(d[15:0], halted ? E_DONE : E_BERR, halted ? "R5" : "R6");
        if (halted) shadow[idx] = d;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int we_before;
        for (int i = 0; i < NREG; i++) shadow[i] = init_val(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        check(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
        check(rf_we == 1'b0, "R1 rf_we", 32'(rf_we), 0);

        // R2/R3: data and address register reads, no delay
        do_read(4'h3, 2'd0, "R3");
        do_read(4'hD, 2'd0, "R3");
        drain();
        check(rf_idx == 4'hD, "R2 rf_idx", 32'(rf_idx), 32'hD);

        // R5: write then read back target and neighbour
        do_write(4'h2, 32'hDEAD_BEEF, 1'b1);
        drain();
        check(we_pulses == 1, "R5 write strobes", 32'(we_pulses), 1);
        do_read(4'h2, 2'd0, "R5");
        do_read(4'h3, 2'd0, "R5");
        do_write(4'hF, 32'h0123_4567, 1'b1);
        do_read(4'hF, 2'd1, "R5");

        // R4: every delay, polled at full rate
        for (int l = 0; l < 4; l++) do_read(4'(l + 8), 2'(l), "R4");

        // R6: refused read, then refused write, then read-back
        drain();
        we_before = we_pulses;
        core_halted = 1'b0;
        send(16'h2185, E_BERR, "R6");
        core_halted = 1'b1;
        do_read(4'h5, 2'd0, "R6");
        do_write(4'h6, 32'hFFFF_0000, 1'b0);
        drain();
        check(we_pulses == we_before, "R6 no write strobe", 32'(we_pulses), 32'(we_before));
        do_read(4'h6, 2'd2, "R6");

        // R7: near-miss and foreign command words
        send(16'h0000, E_ILL, "R7");
        send(16'h2280, E_ILL, "R7");
        send(16'h2190, E_ILL, "R7");
        send(16'h3182, E_ILL, "R7");
        send(16'h2F86, E_ILL, "R7");
        send(16'hFFFF, E_ILL, "R7");
        drain();
        check(we_pulses == we_before, "R7 no write strobe", 32'(we_pulses), 32'(we_before));
        do_read(4'h2, 2'd0, "R7");

        // R8: stalled consumer holds the response and blocks new words
        drain();
        send(16'h2184, E_ACK, "R2");
        drain();
        @(posedge clk);
        #1 rsp_ready = 1'b0;
        send(16'h0000, {1'b0, shadow[4][31:16]}, "R8");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(rsp_valid == 1'b1, "R8 held valid", 32'(rsp_valid), 1);
            check(cmd_ready == 1'b0, "R8 blocked", 32'(cmd_ready), 0);
            check(rsp_word == {1'b0, shadow[4][31:16]}, "R8 held word",
                  32'(rsp_word), 32'({1'b0, shadow[4][31:16]}));
        end
        @(posedge clk);
        #1 rsp_ready = 1'b1;
        send(16'h0000, {1'b0, shadow[4][15:0]}, "R8");
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all answered", 32'(exp_q.size()), 0);
        check(rsp_valid == 1'b0, "R8 no extra response", 32'(rsp_valid), 0);
        finish_run();
    end

endmodule